// File: doc/BRIEF.md
# Sleep Entry and Wake-Up Controller

This block puts a small processor core to sleep and brings it back. A one-cycle halt strobe from the core drops the system clock enable. The core then holds its registers and port outputs unchanged until a wake source appears. The whole block runs on an always-on clock. A watchdog counter inside it either keeps running during sleep or freezes with the system clock, as set by a configuration input.

While the core sleeps, the block watches four wake sources: an external reset request, a watchdog overflow, a pending interrupt, and a falling edge on any port pin whose wake bit is set. When one or more sources appear, it records the winning cause and waits a fixed settle time that stands in for oscillator start-up. It then raises the clock enable again and fires exactly one action pulse: full core reset, program-counter/stack-pointer reset, resume at the next instruction, or interrupt vectoring. Two status flags tell software how the last sleep ended: a power-down flag and a timeout flag.

The states are RUN (clock on), SLEEP (clock off, sources watched), SETTLE (clock off, start-up delay counting) and WAKE (clock on, one-cycle action). The transitions are:
- halt: RUN to SLEEP.
- source-seen: SLEEP to SETTLE.
- settled: SETTLE to WAKE.
- run-event (external reset or watchdog overflow while running): RUN straight to WAKE.
- done: WAKE to RUN.

Top module: `pdw_ctrl`

## Requirements
- R1: A halt strobe in RUN, with no reset request or watchdog overflow in that cycle, drops `sys_clk_en` from the next cycle. The enable stays low through SLEEP and SETTLE.
- R2: Power-up reset clears both flags. Halt sets `pdf` and clears `to_flag`. The clear-watchdog strobe in RUN clears both flags and the watchdog count. If both strobes come together, halt wins.
- R3: The halt, clear-watchdog and wake events clear the watchdog count. The count advances every cycle in RUN. In SLEEP it advances only when `wdt_src_sys` is 0; with `wdt_src_sys` = 1 it is frozen. An overflow happens on the 2^WDT_W-th advance after a clear and sets `to_flag`.
- R4: `wake_cause` is one-hot: bit0 reset, bit1 watchdog, bit2 interrupt-vector, bit3 interrupt-resume, bit4 port. It holds until the next wake. When sources coincide, the priority is reset, then watchdog, then interrupt, then port.
- R5: An external reset wake pulses `core_rst` for one cycle and leaves both flags unchanged.
- R6: A watchdog wake pulses `pcsp_rst` for one cycle, sets `to_flag` and keeps `pdf`.
- R7: Port pins pass through a two-flop synchronizer. A high-to-low change on a pin whose `pa_wake_en` bit is 1 wakes the core with a `resume` pulse. A pin whose bit is 0 never wakes it.
- R8: An interrupt wake with `irq_en`=1 and `stack_full`=0 pulses `vector`. Otherwise it pulses `resume` with the interrupt-resume cause.
- R9: A level source present at clock edge k gives the action pulse, together with `sys_clk_en` high, after edge k+SETTLE. The pulse lasts one cycle. A port edge adds two synchronizer cycles.
- R10: In RUN, an external reset or a watchdog overflow gives its action pulse in the next cycle, with no settle time. Port edges and interrupts in RUN produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| halt_stb | input | 1 | One-cycle halt instruction strobe |
| clrwdt_stb | input | 1 | One-cycle clear-watchdog strobe |
| wdt_src_sys | input | 1 | 1: watchdog clocked from system clock (frozen in sleep) |
| ext_rst | input | 1 | External reset request |
| pa_in | input | PA_W | Port pin levels (asynchronous) |
| pa_wake_en | input | PA_W | Per-pin wake enable |
| irq_pend | input | 1 | Interrupt request pending |
| irq_en | input | 1 | Pending interrupt is enabled |
| stack_full | input | 1 | Call stack has no free level |
| sys_clk_en | output | 1 | System clock enable |
| pdf | output | 1 | Power-down flag |
| to_flag | output | 1 | Watchdog timeout flag |
| core_rst | output | 1 | Full core reset pulse |
| pcsp_rst | output | 1 | Program counter / stack pointer reset pulse |
| resume | output | 1 | Resume-after-halt pulse |
| vector | output | 1 | Interrupt vectoring pulse |
| wake_cause | output | 5 | One-hot cause of the last wake |

## Verification
The bench builds the block with `WDT_WIDTH`=4, `SETTLE`=4 and `PA_W`=8. With a watchdog of only 16 ticks, overflow during sleep, overflow while running, and an overflow that lands in the same cycle as an interrupt can all be timed exactly. The short settle time lets the bench check the wake latency on every path. With this size, the bench can sweep every port pin alone and every mix of reset, interrupt and port sources against all four enable/stack-full settings.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_WAKE   = 2'd3
    } pdw_state_e;

    localparam int CAUSE_W = 5;
    localparam int CI_RESET = 0;
    localparam int CI_WDT   = 1;
    localparam int CI_VEC   = 2;
    localparam int CI_IRES  = 3;
    localparam int CI_PORT  = 4;

    // Resolve simultaneous wake sources into one cause bit.
    function automatic logic [CAUSE_W-1:0] pick_cause(
        input logic rst_req,
        input logic wdt_ovf,
        input logic irq,
        input logic irq_on,
        input logic stk_full,
        input logic port_fall
    );
        logic [CAUSE_W-1:0] c;
        c = '0;
        if (rst_req)        c[CI_RESET] = 1'b1;
        else if (wdt_ovf)   c[CI_WDT]   = 1'b1;
        else if (irq) begin
            if (irq_on && !stk_full) c[CI_VEC]  = 1'b1;
            else                     c[CI_IRES] = 1'b1;
        end
        else if (port_fall) c[CI_PORT]  = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/pdw_pin_edge.sv
module pdw_pin_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pin_en,
    output logic [W-1:0] fall
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic meta_q, sync_q, prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= 1'b1;
                    sync_q <= 1'b1;
                    prev_q <= 1'b1;
                end else begin
                    meta_q <= pin_in[i];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end

            assign fall[i] = prev_q & ~sync_q & pin_en[i];

            // R7: an edge flagged on a pin means the synchronized level just went low
            a_r7_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
                fall[i] |=> !prev_q);
        end
    endgenerate

endmodule

// File: rtl/pdw_wdt.sv
module pdw_wdt #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic ovf
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    assign ovf = tick & (&cnt_q) & ~clear;

    // R3: overflow always leaves the counter at zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0));

    // R3: without a tick or clear the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
    import pdw_pkg::*;
#(
    parameter int PA_W      = 8,
    parameter int WDT_WIDTH = 10,
    parameter int SETTLE    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_stb,
    input  logic                clrwdt_stb,
    input  logic                wdt_src_sys,
    input  logic                ext_rst,
    input  logic [PA_W-1:0]     pa_in,
    input  logic [PA_W-1:0]     pa_wake_en,
    input  logic                irq_pend,
    input  logic                irq_en,
    input  logic                stack_full,
    output logic                sys_clk_en,
    output logic                pdf,
    output logic                to_flag,
    output logic                core_rst,
    output logic                pcsp_rst,
    output logic                resume,
    output logic                vector,
    output logic [CAUSE_W-1:0]  wake_cause
);

    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);

    pdw_state_e          state_q, state_d;
    logic [SW-1:0]       settle_q;
    logic [CAUSE_W-1:0]  cause_q, sleep_cause;
    logic                pdf_q, to_q;
    logic [PA_W-1:0]     fall;
    logic                port_any, wake_any, ovf;
    logic                in_run, in_sleep, wdt_tick, wdt_clear;

    assign in_run   = (state_q == ST_RUN);
    assign in_sleep = (state_q == ST_SLEEP);

    pdw_pin_edge #(.W(PA_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pa_in),
        .pin_en (pa_wake_en),
        .fall   (fall)
    );

    assign wdt_tick  = in_run | (in_sleep & ~wdt_src_sys);
    assign wdt_clear = ~(in_run | in_sleep) | (in_run & (halt_stb | clrwdt_stb));

    pdw_wdt #(.W(WDT_WIDTH)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (wdt_tick),
        .clear (wdt_clear),
        .ovf   (ovf)
    );

    assign port_any    = |fall;
    assign sleep_cause = pick_cause(ext_rst, ovf, irq_pend, irq_en, stack_full, port_any);
    assign wake_any    = |sleep_cause;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ext_rst || ovf)  state_d = ST_WAKE;   // run-event
                else if (halt_stb)   state_d = ST_SLEEP;  // halt
            end
            ST_SLEEP:  if (wake_any) state_d = ST_SETTLE; // source-seen
            ST_SETTLE: if (settle_q == SETTLE_LAST) state_d = ST_WAKE; // settled
            ST_WAKE:   state_d = ST_RUN;                  // done
            default:   state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // settle counter, cause and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
            cause_q  <= '0;
            pdf_q    <= 1'b0;
            to_q     <= 1'b0;
        end else begin
            settle_q <= (state_q == ST_SETTLE) ? settle_q + 1'b1 : '0;
            unique case (state_q)
                ST_RUN: begin
                    if (ext_rst) begin
                        cause_q <= CAUSE_W'(1) << CI_RESET;
                    end else if (ovf) begin
                        cause_q <= CAUSE_W'(1) << CI_WDT;
                        to_q    <= 1'b1;
                    end else if (halt_stb) begin
                        pdf_q <= 1'b1;
                        to_q  <= 1'b0;
                    end else if (clrwdt_stb) begin
                        pdf_q <= 1'b0;
                        to_q  <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (wake_any) begin
                        cause_q <= sleep_cause;
                        if (sleep_cause[CI_WDT]) to_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sys_clk_en = in_run | (state_q == ST_WAKE);
        core_rst   = (state_q == ST_WAKE) & cause_q[CI_RESET];
        pcsp_rst   = (state_q == ST_WAKE) & cause_q[CI_WDT];
        vector     = (state_q == ST_WAKE) & cause_q[CI_VEC];
        resume     = (state_q == ST_WAKE) & (cause_q[CI_IRES] | cause_q[CI_PORT]);
        wake_cause = cause_q;
        pdf        = pdf_q;
        to_flag    = to_q;
    end

    // R1: halt stops the clock and updates the flags
    a_r1_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && halt_stb && !ext_rst && !ovf) |=> (!sys_clk_en && pdf && !to_flag));

    // R4: never more than one action at a time
    a_r4_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_rst, pcsp_rst, resume, vector}));

    // R9: the clock returning always comes with exactly one action
    a_r9_rise_action: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_clk_en) |-> ($countones({core_rst, pcsp_rst, resume, vector}) == 1));

    // R9: action pulses only with the clock running
    a_r9_action_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst || pcsp_rst || resume || vector) |-> sys_clk_en);

    // R6: watchdog reset implies timeout flag
    a_r6_wdt_to: assert property (@(posedge clk) disable iff (!rst_n)
        pcsp_rst |-> to_flag);

    // R5: external reset wake keeps the flags
    a_r5_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && ext_rst) |=> ($stable(pdf) && $stable(to_flag)));

    // R3: watchdog frozen in sleep when on the system clock
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && wdt_src_sys) |-> !ovf);

    // R10: no resume or vector straight out of RUN
    a_r10_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_run |=> !(resume || vector));

endmodule

// File: tb/pdw_ctrl_test.sv
module pdw_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int PA_W  = 8;
    localparam int WW    = 4;
    localparam int ST    = 4;
    localparam int WPER  = 1 << WW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_stb = 0, clrwdt_stb = 0, wdt_src_sys = 1, ext_rst = 0;
    logic [PA_W-1:0] pa_in = '1, pa_wake_en = '0;
    logic irq_pend = 0, irq_en = 0, stack_full = 0;
    logic sys_clk_en, pdf, to_flag, core_rst, pcsp_rst, resume, vector;
    logic [4:0] wake_cause;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdw_ctrl #(.PA_W(PA_W), .WDT_WIDTH(WW), .SETTLE(ST)) uut (
        .clk(clk), .rst_n(rst_n), .halt_stb(halt_stb), .clrwdt_stb(clrwdt_stb),
        .wdt_src_sys(wdt_src_sys), .ext_rst(ext_rst), .pa_in(pa_in),
        .pa_wake_en(pa_wake_en), .irq_pend(irq_pend), .irq_en(irq_en),
        .stack_full(stack_full), .sys_clk_en(sys_clk_en), .pdf(pdf),
        .to_flag(to_flag), .core_rst(core_rst), .pcsp_rst(pcsp_rst),
        .resume(resume), .vector(vector), .wake_cause(wake_cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pulses();
        return {28'd0, core_rst, pcsp_rst, resume, vector};
    endfunction

    task automatic do_halt();
        @(negedge clk); halt_stb = 1;
        @(negedge clk); halt_stb = 0;
        chk(!sys_clk_en, "R1 clock off after halt", sys_clk_en, 0);
        chk(pdf && !to_flag, "R2 halt flags", {pdf, to_flag}, 2);
    endtask

    task automatic wait_wake(output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!sys_clk_en && n < 200);
    endtask

    // check the pulse in the wake cycle and its end one cycle later
    task automatic chk_wake(input string req, input int n, input int n_exp,
                            input int cause_exp, input int pul_exp);
        chk(n == n_exp, {req, " latency R9"}, n, n_exp);
        chk(wake_cause == cause_exp, {req, " cause R4"}, wake_cause, cause_exp);
        chk(pulses() == pul_exp, {req, " pulse"}, pulses(), pul_exp);
        @(negedge clk);
        chk(pulses() == 0 && sys_clk_en, {req, " pulse one cycle R9"}, pulses(), 0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(sys_clk_en && !pdf && !to_flag && wake_cause == 0 && pulses() == 0,
            "R2 reset state", {sys_clk_en, pdf, to_flag}, 4);
        rst_n = 1;
        @(negedge clk);

        // R8: interrupt with enable, stack free -> vector; frozen watchdog R3
        do_halt();
        repeat (2 * WPER) @(negedge clk);
        chk(!sys_clk_en, "R3 frozen watchdog keeps sleep", sys_clk_en, 0);
        irq_pend = 1; irq_en = 1; stack_full = 0;
        wait_wake(n);
        chk(pdf && !to_flag, "R8 flags after irq wake", {pdf, to_flag}, 2);
        chk_wake("R8 vector", n, ST + 1, 4, 1);
        irq_pend = 0;

        // R8: disabled interrupt and full stack -> resume
        for (int k = 0; k < 2; k++) begin
            do_halt();
            irq_pend = 1; irq_en = (k == 1); stack_full = (k == 1);
            wait_wake(n);
            chk_wake("R8 resume", n, ST + 1, 8, 2);
            irq_pend = 0; irq_en = 0; stack_full = 0;
        end

        // R7: per-pin sweep, disabled pin ignored then enabled pin wakes
        for (int p = 0; p < PA_W; p++) begin
            int q;
            q = (p + 1) % PA_W;
            pa_wake_en = PA_W'(1) << p;
            do_halt();
            pa_in[q] = 1'b0;
            repeat (8) @(negedge clk);
            chk(!sys_clk_en && pulses() == 0, "R7 disabled pin ignored", sys_clk_en, 0);
            pa_in[p] = 1'b0;
            wait_wake(n);
            chk_wake("R7 port wake", n, ST + 3, 16, 2);
            pa_in = '1;
            repeat (3) @(negedge clk);
        end
        pa_wake_en = '0;

        // R5: external reset wake keeps flags
        do_halt();
        ext_rst = 1;
        wait_wake(n);
        ext_rst = 0;
        chk(pdf && !to_flag, "R5 flags kept", {pdf, to_flag}, 2);
        chk_wake("R5 ext reset", n, ST + 1, 1, 8);

        // R6/R3: watchdog wake with running watchdog in sleep
        wdt_src_sys = 0;
        @(negedge clk); halt_stb = 1;
        @(negedge clk); halt_stb = 0;
        n = 1;
        do begin @(negedge clk); n++; end while (!sys_clk_en && n < 200);
        chk(to_flag && pdf, "R6 TO set PDF kept", {pdf, to_flag}, 3);
        chk_wake("R6 wdt wake R3", n, WPER + ST + 1, 2, 4);

        // R2: clear-watchdog clears both flags
        @(negedge clk); clrwdt_stb = 1;
        @(negedge clk); clrwdt_stb = 0;
        chk(!pdf && !to_flag, "R2 clrwdt flags", {pdf, to_flag}, 0);

        // R10: overflow while running, with irq and port edge ignored in RUN
        pa_wake_en = '1;
        irq_pend = 1; irq_en = 1;
        pa_in[3] = 1'b0;
        n = 1;
        while (!pcsp_rst && n < 200) begin
            @(negedge clk); n++;
            if (!pcsp_rst)
                chk(!resume && !vector && sys_clk_en, "R10 RUN ignores irq/port", pulses(), 0);
        end
        chk(n == WPER + 1, "R10 run overflow latency R3", n, WPER + 1);
        chk(to_flag && !pdf, "R10 run overflow flags", {pdf, to_flag}, 1);
        chk(wake_cause == 2, "R10 run overflow cause", wake_cause, 2);
        irq_pend = 0; irq_en = 0; pa_in = '1; pa_wake_en = '0;
        @(negedge clk);

        // R10: external reset while running
        ext_rst = 1;
        @(negedge clk); ext_rst = 0;
        chk(core_rst && wake_cause == 1, "R10 run ext reset", pulses(), 8);
        @(negedge clk);

        // R4: watchdog beats a simultaneous interrupt
        @(negedge clk); halt_stb = 1;
        @(negedge clk); halt_stb = 0;
        repeat (WPER - 1) @(negedge clk);
        irq_pend = 1; irq_en = 1;
        wait_wake(n);
        chk_wake("R4 wdt over irq", n, ST + 1, 2, 4);
        irq_pend = 0; irq_en = 0;
        wdt_src_sys = 1;

        // R4: priority sweep over reset/interrupt/port and enable/stack settings
        pa_wake_en = 8'h01;
        for (int m = 1; m < 8; m++) begin
            for (int c = 0; c < 4; c++) begin
                int ce, pe;
                do_halt();
                if (m[2]) pa_in[0] = 1'b0;
                repeat (2) @(negedge clk);
                ext_rst = m[0]; irq_pend = m[1]; irq_en = c[0]; stack_full = c[1];
                if (m[0])                    begin ce = 1;  pe = 8; end
                else if (m[1] && c == 1)     begin ce = 4;  pe = 1; end
                else if (m[1])               begin ce = 8;  pe = 2; end
                else                         begin ce = 16; pe = 2; end
                wait_wake(n);
                ext_rst = 0; irq_pend = 0; irq_en = 0; stack_full = 0;
                chk_wake("R4 priority", n, ST + 1, ce, pe);
                pa_in = '1;
                repeat (3) @(negedge clk);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule